// File: doc/BRIEF.md
# PLL Divider Search Engine

This block chooses the divider settings of a frequency synthesizer by trying them all. A request in hundredths of a megahertz is first limited to the synthesizer's working band. The limited value is then rescaled into an 8-bit fixed-point target. The block works out a power-of-two prescale exponent, and then visits every pair of feedback divider M and reference divider N in a fixed order. For each pair it computes the output frequency that the synthesizer would produce and measures how far that is from the target. The pair with the smallest error is packed into a 16-bit program word.

The search uses one shared 32-bit restoring divider. The divider retires several quotient bits per clock, so each candidate pair costs a fixed number of cycles. A request is accepted with a one-cycle `start` pulse while the block is idle. `busy` is high for the whole search. `done` pulses for one cycle when `prog_word` has been updated. A debug count of the busy cycles of the last request is also provided, so the timing can be checked from outside.

Top module: `pllsrch_top`

## Requirements
- R1: After reset, `busy` and `done` are 0, `prog_word` is 0 and `run_cycles` is 0.
- R2: A request of 0 performs no search. In the cycle after `start`, `done` is 1 and `prog_word` is 0x00E0. `busy` never rises and `run_cycles` reads 0.
- R3: A non-zero request is limited to the band 8000..15938. A smaller request gives the same word as 8000, and a larger one gives the same word as 15938.
- R4: The target is the limited request times 256, divided by 100 with truncation. It is taken before any doubling of the request.
- R5: The prescale exponent k starts at 0. While the working value is below 64000, the value doubles and k increments. k appears in `prog_word[7:6]`.
- R6: The search covers M = 2..30 in the outer loop and N = 35..247 in the inner loop. The candidate output is floor(938356 × (N + 8) / (2^k × 256 × (M + 2))).
- R7: A candidate replaces the best pair only when its absolute error against the target is strictly smaller than the best error so far. The best error starts at 0xFFFFFFFF, so on a tie the earlier pair stays.
- R8: `prog_word` = (N << 8) + (k << 6) + M. This puts N in bits 15:8, k in bits 7:6 and M in bits 5:0.
- R9: `busy` is high from the cycle after `start` until `done`. `done` is a single-cycle pulse and is never high together with `busy`. For a non-zero request, `run_cycles` ends at (k + 1) + 6177 × 4: each candidate takes 4 cycles.
- R10: A `start` that arrives while `busy` is high is ignored. The result is that of the request that was accepted.
- R11: `prog_word` changes only in the cycle in which `done` is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, honoured only while idle |
| freq_req | input | 16 | Requested frequency in 0.01 MHz units |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when `prog_word` is new |
| prog_word | output | 16 | Packed N, k and M of the best pair |
| run_cycles | output | 32 | Busy cycles used by the last request (debug) |

## Verification
A zero request is due one cycle after `start`. A non-zero request first spends k + 1 cycles on prescaling and then 4 cycles per candidate pair. With the fixed band this always gives 24712 busy cycles, and `done` appears in the cycle after the last one. The bench drives and samples on the falling edge and counts falling edges from `start`. It requires `done` on exactly edge `run_cycles + 1`, with the count and the word compared against its own nested-loop model. One edge later it checks that `done` has dropped and the word is held.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;
  localparam int unsigned FREQ_W  = 16;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned ARITH_W = 32;

  typedef logic [ARITH_W-1:0] arith_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCALE,
    ST_SEARCH
  } srch_state_e;

  // R3: band limit
  function automatic arith_t clamp_freq(input arith_t f, input arith_t lo, input arith_t hi);
    if (f < lo) return lo;
    if (f > hi) return hi;
    return f;
  endfunction

  // R4: 8-bit fixed-point target
  function automatic arith_t target_of(input arith_t f);
    return (f << 8) / arith_t'(100);
  endfunction

  function automatic arith_t abs_gap(input arith_t a, input arith_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // R6: candidate numerator and denominator
  function automatic arith_t cand_num(input arith_t refc, input arith_t n);
    return refc * (n + arith_t'(8));
  endfunction

  function automatic arith_t cand_den(input arith_t m, input arith_t k);
    return (m + arith_t'(2)) << (k + arith_t'(8));
  endfunction

  // R8: field placement
  function automatic logic [WORD_W-1:0] pack_word(input arith_t k, input arith_t m, input arith_t n);
    return WORD_W'((n << 8) + (k << 6) + m);
  endfunction
endpackage

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
  parameter int unsigned W   = 32,
  parameter int unsigned BPC = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic         fin
);
  localparam int unsigned STEPS = W / BPC;
  localparam int unsigned CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [W-1:0]  dvd_q, dsr_q, rem_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W-1:0]  dvd_nxt, rem_nxt;

  // BPC restoring steps per clock; quotient bits shift into the dividend register
  always_comb begin
    logic [W:0] sh;
    dvd_nxt = dvd_q;
    rem_nxt = rem_q;
    for (int i = 0; i < int'(BPC); i++) begin
      sh      = {rem_nxt, dvd_nxt[W-1]};
      dvd_nxt = {dvd_nxt[W-2:0], 1'b0};
      if (sh >= {1'b0, dsr_q}) begin
        sh         = sh - {1'b0, dsr_q};
        dvd_nxt[0] = 1'b1;
      end
      rem_nxt = sh[W-1:0];
    end
  end

  assign fin  = run_q && (cnt_q == CW'(STEPS - 1));
  assign quot = dvd_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q <= '0;
      dsr_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      dvd_q <= dividend;
      dsr_q <= divisor;
      rem_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      dvd_q <= dvd_nxt;
      rem_q <= rem_nxt;
      cnt_q <= cnt_q + CW'(1);
      if (fin) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pllsrch_pick.sv
module pllsrch_pick #(
  parameter int unsigned MN_W  = 8,
  parameter int unsigned ERR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             eval,
  input  logic [ERR_W-1:0] err,
  input  logic [MN_W-1:0]  cand_m,
  input  logic [MN_W-1:0]  cand_n,
  output logic             take,
  output logic [MN_W-1:0]  win_m,
  output logic [MN_W-1:0]  win_n,
  output logic [ERR_W-1:0] best_err
);
  logic [MN_W-1:0] best_m_q, best_n_q;

  // R7: strict improvement only, so the first minimum stays
  assign take  = eval && (err < best_err);
  assign win_m = take ? cand_m : best_m_q;
  assign win_n = take ? cand_n : best_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_err <= '1;
      best_m_q <= '0;
      best_n_q <= '0;
    end else if (clear) begin
      best_err <= '1;
      best_m_q <= '0;
      best_n_q <= '0;
    end else if (take) begin
      best_err <= err;
      best_m_q <= cand_m;
      best_n_q <= cand_n;
    end
  end
endmodule

// File: rtl/pllsrch_top.sv
module pllsrch_top
  import pllsrch_pkg::*;
#(
  parameter int unsigned      REF_NUM    = 938356,
  parameter int unsigned      F_LO       = 8000,
  parameter int unsigned      F_HI       = 15938,
  parameter int unsigned      SCALE_MULT = 8,
  parameter int unsigned      M_MIN      = 2,
  parameter int unsigned      M_MAX      = 30,
  parameter int unsigned      N_MIN      = 35,
  parameter int unsigned      N_MAX      = 247,
  parameter int unsigned      DIV_BPC    = 8,
  parameter logic [WORD_W-1:0] ZERO_WORD = 16'h00E0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [FREQ_W-1:0]   freq_req,
  output logic                busy,
  output logic                done,
  output logic [WORD_W-1:0]   prog_word,
  output logic [ARITH_W-1:0]  run_cycles
);
  localparam int unsigned MN_W = $clog2(((M_MAX > N_MAX) ? M_MAX : N_MAX) + 2);
  localparam int unsigned K_W  = $clog2($clog2(SCALE_MULT) + 2);
  localparam arith_t SCALE_LIMIT = arith_t'(F_LO * SCALE_MULT);

  srch_state_e       state_q;
  arith_t            scaled_q, target_q, cyc_q;
  logic [K_W-1:0]    k_q;
  logic [MN_W-1:0]   m_q, n_q;
  logic [WORD_W-1:0] word_q;
  logic              done_q;

  // named internal events
  logic            accept, req_zero, scale_more, scale_exit;
  logic            last_pair, n_wrap, div_load, cand_fin, cand_take, search_done;
  logic [MN_W-1:0] nxt_m, nxt_n, ld_m, ld_n, win_m, win_n;
  arith_t          req_clamped, div_num, div_den, div_quot, cand_err, best_err;

  assign accept      = start && (state_q == ST_IDLE);   // R10
  assign req_zero    = (freq_req == '0);                // R2
  assign req_clamped = clamp_freq(arith_t'(freq_req), arith_t'(F_LO), arith_t'(F_HI));
  assign scale_more  = (scaled_q < SCALE_LIMIT);        // R5
  assign scale_exit  = (state_q == ST_SCALE) && !scale_more;

  // R6: M outer, N inner
  assign n_wrap    = (n_q == MN_W'(N_MAX));
  assign last_pair = n_wrap && (m_q == MN_W'(M_MAX));
  assign nxt_m     = n_wrap ? (m_q + MN_W'(1)) : m_q;
  assign nxt_n     = n_wrap ? MN_W'(N_MIN) : (n_q + MN_W'(1));
  assign ld_m      = scale_exit ? MN_W'(M_MIN) : nxt_m;
  assign ld_n      = scale_exit ? MN_W'(N_MIN) : nxt_n;

  assign div_load    = scale_exit || (cand_fin && !last_pair);
  assign div_num     = cand_num(arith_t'(REF_NUM), arith_t'(ld_n));
  assign div_den     = cand_den(arith_t'(ld_m), arith_t'(k_q));
  assign cand_err    = abs_gap(target_q, div_quot);
  assign search_done = cand_fin && last_pair;

  pllsrch_div #(
    .W   (ARITH_W),
    .BPC (DIV_BPC)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_load),
    .dividend (div_num),
    .divisor  (div_den),
    .quot     (div_quot),
    .fin      (cand_fin)
  );

  pllsrch_pick #(
    .MN_W  (MN_W),
    .ERR_W (ARITH_W)
  ) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .eval     (cand_fin),
    .err      (cand_err),
    .cand_m   (m_q),
    .cand_n   (n_q),
    .take     (cand_take),
    .win_m    (win_m),
    .win_n    (win_n),
    .best_err (best_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      scaled_q <= '0;
      target_q <= '0;
      cyc_q    <= '0;
      k_q      <= '0;
      m_q      <= '0;
      n_q      <= '0;
      word_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q != ST_IDLE) cyc_q <= cyc_q + arith_t'(1);   // R9
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cyc_q <= '0;
            if (req_zero) begin
              word_q <= ZERO_WORD;
              done_q <= 1'b1;
            end else begin
              scaled_q <= req_clamped;
              target_q <= target_of(req_clamped);   // R4: before doubling
              k_q      <= '0;
              state_q  <= ST_SCALE;
            end
          end
        end
        ST_SCALE: begin
          if (scale_more) begin
            scaled_q <= scaled_q << 1;
            k_q      <= k_q + K_W'(1);
          end else begin
            m_q     <= ld_m;
            n_q     <= ld_n;
            state_q <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (search_done) begin
            word_q  <= pack_word(arith_t'(k_q), arith_t'(win_m), arith_t'(win_n));
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (cand_fin) begin
            m_q <= ld_m;
            n_q <= ld_n;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign prog_word  = word_q;
  assign run_cycles = cyc_q;
endmodule

// File: rtl/pllsrch_chk.sv
module pllsrch_chk #(
  parameter int unsigned M_MIN = 2,
  parameter int unsigned M_MAX = 30,
  parameter int unsigned N_MIN = 35,
  parameter int unsigned N_MAX = 247
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [15:0] freq_req,
  input logic        busy,
  input logic        done,
  input logic [15:0] prog_word,
  input logic [31:0] run_cycles,
  input logic        cand_fin,
  input logic [31:0] best_err
);
  p_zero_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && freq_req == 16'h0000) |=> (done && !busy && prog_word == 16'h00E0));

  p_best_monotone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_fin |=> (best_err <= $past(best_err)));

  p_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prog_word != 16'h00E0) |->
      (prog_word[5:0] >= 6'(M_MIN) && prog_word[5:0] <= 6'(M_MAX) &&
       prog_word[15:8] >= 8'(N_MIN) && prog_word[15:8] <= 8'(N_MAX)));

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && freq_req == 16'h0000)) |=> !done);

  p_cycle_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (run_cycles == $past(run_cycles) + 32'd1));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prog_word) |-> done);
endmodule

bind pllsrch_top pllsrch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .freq_req   (freq_req),
  .busy       (busy),
  .done       (done),
  .prog_word  (prog_word),
  .run_cycles (run_cycles),
  .cand_fin   (cand_fin),
  .best_err   (best_err)
);

// File: tb/pllsrch_top_tb.sv
module pllsrch_top_tb;
  localparam int CLK_PERIOD    = 10;
  localparam int WATCHDOG      = 180000;
  localparam int CYC_PER_CAND  = 4;          // 32 quotient bits, 8 per clock
  localparam int PAIRS         = 29 * 213;   // R6 ranges
  localparam int WAIT_CAP      = 40000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] freq_req;
  logic        busy, done;
  logic [15:0] prog_word;
  logic [31:0] run_cycles;

  int checks = 0;
  int fails  = 0;

  pllsrch_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .freq_req   (freq_req),
    .busy       (busy),
    .done       (done),
    .prog_word  (prog_word),
    .run_cycles (run_cycles)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int band(input int f);
    if (f < 8000)  return 8000;
    if (f > 15938) return 15938;
    return f;
  endfunction

  function automatic int model_k(input int f);
    int v = band(f);
    int k = 0;
    while (v < 64000) begin
      v = v * 2;
      k++;
    end
    return k;
  endfunction

  function automatic int model_word(input int f);
    longint tgt, best, fo, d;
    int k, bm, bn;
    if (f == 0) return 'h00E0;
    tgt  = longint'(band(f)) * 256 / 100;
    k    = model_k(f);
    best = 64'hFFFF_FFFF;
    bm   = 0;
    bn   = 0;
    for (int m = 2; m <= 30; m++) begin
      for (int n = 35; n <= 247; n++) begin
        fo = (longint'(938356) * (n + 8)) / ((longint'(1) << k) * 256 * (m + 2));
        d  = (tgt > fo) ? tgt - fo : fo - tgt;
        if (d < best) begin
          best = d;
          bm   = m;
          bn   = n;
        end
      end
    end
    return (bn << 8) + (k << 6) + bm;
  endfunction

  function automatic int model_cycles(input int f);
    if (f == 0) return 0;
    return model_k(f) + 1 + PAIRS * CYC_PER_CAND;
  endfunction

  // Issue one request; optionally pulse start with another value mid-run.
  task automatic issue(input int f, input bit poke, input int poke_f,
                       output int lat, output bit busy_ok);
    @(negedge clk);
    start    = 1'b1;
    freq_req = 16'(f);
    @(negedge clk);
    start    = 1'b0;
    lat      = 1;
    busy_ok  = 1'b1;
    while (!done && lat < WAIT_CAP) begin
      if (busy !== 1'b1) busy_ok = 1'b0;
      if (poke && lat == 50) begin
        start    = 1'b1;
        freq_req = 16'(poke_f);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  task automatic finish_checks(input string tag, input int f, input int lat);
    logic [15:0] w;
    check(tag, "done latency (R9)", lat, model_cycles(f) + 1);
    check(tag, "run_cycles (R9)", run_cycles, model_cycles(f));
    check(tag, "busy low at done (R9)", busy, 0);
    w = prog_word;
    @(negedge clk);
    check(tag, "done single pulse (R9)", done, 0);
    repeat (3) @(negedge clk);
    check(tag, "word held after done (R11)", prog_word, w);
  endtask

  task automatic test_reset;
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "prog_word", prog_word, 0);
    check("R1", "run_cycles", run_cycles, 0);
  endtask

  task automatic test_zero;
    int lat;
    bit bo;
    issue(0, 1'b0, 0, lat, bo);
    check("R2", "latency", lat, 1);
    check("R2", "word", prog_word, 'h00E0);
    check("R2", "busy stays low", busy, 0);
    finish_checks("R2", 0, lat);
  endtask

  task automatic test_restart_ignored;
    int lat;
    bit bo;
    issue(10000, 1'b1, 12000, lat, bo);
    check("R10", "busy held through run", bo, 1);
    check("R10", "word of accepted request", prog_word, model_word(10000));
    finish_checks("R10", 10000, lat);
  endtask

  task automatic test_clamp_low;
    int lat;
    bit bo;
    issue(500, 1'b0, 0, lat, bo);
    check("R3", "low request equals 8000 result", prog_word, model_word(8000));
    finish_checks("R3", 500, lat);
  endtask

  task automatic test_clamp_high;
    int lat;
    bit bo;
    issue(60000, 1'b0, 0, lat, bo);
    check("R3", "high request equals 15938 result", prog_word, model_word(15938));
    finish_checks("R3", 60000, lat);
  endtask

  task automatic test_fields;
    int lat;
    bit bo;
    int exp;
    issue(13500, 1'b0, 0, lat, bo);
    exp = model_word(13500);
    check("R4 R6 R7", "best pair word", prog_word, exp);
    check("R5", "prescale field [7:6]", prog_word[7:6], model_k(13500));
    check("R8", "M field [5:0]", prog_word[5:0], exp & 'h3F);
    check("R8", "N field [15:8]", prog_word[15:8], (exp >> 8) & 'hFF);
    finish_checks("R8", 13500, lat);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    freq_req = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_zero();
    test_restart_ignored();
    test_clamp_low();
    test_clamp_high();
    test_fields();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule